// File: doc/BRIEF.md
# Single-Bit Recency Replacement Controller

This block holds the replacement state of a set-associative cache in which every way carries one recency flag. A hit on a way raises that way's flag, and so does a fill. When raising a flag would leave every flag in a set high, all other flags in that set drop to zero. Only the flag just accessed stays high. A fill asks which way to evict. The answer is the lowest-numbered way whose flag is low, taken from the state the set holds in that cycle.

The cache around the block drives a hit strobe with a set number and a way number. It drives a fill request with a set number and reads back the victim way in the same cycle. On the clock edge that ends a fill cycle, the block marks the victim as accessed. A small array of independent sets can be kept, and each set updates only on accesses that name it. The flag vector of the set named by the fill-set input is visible as a read-only output.

Top module: `mru_repl_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, every flag of every set is zero and the victim reported is way 0.
- R2: A hit to way w of a set raises flag w of that set at the next clock edge. The other flags do not change unless R4 applies.
- R3: The victim is the lowest way index whose flag is zero, taken from the set selected by the fill-set input.
- R4: If an access would leave every flag in the set high, the set's vector becomes a single high flag at the accessed way.
- R5: A fill on a clock edge applies the R2/R4 update to the victim reported during that cycle.
- R6: If a hit and a fill target the same set in one cycle, the hit is applied first. The victim is computed from the vector after the hit, and both updates land at the same edge.
- R7: A hit whose way index is equal to or above the way count changes no state.
- R8: Accesses to one set never change the flags of another set.
- R9: The victim index is 4 bits wide for 12 ways, and it is always below the way count.
- R10: Start from reset with an empty cache and 13 addresses that all map to one set. Replay, each round, one target, the first ten conflict addresses, the eleventh, the first nine again, then the twelfth. From the third round on, exactly two accesses per round miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | Hit strobe |
| hit_set | input | SET_W | Set of the hit |
| hit_way | input | IDX_W | Way that hit |
| fill_req | input | 1 | Fill request; the victim is consumed at the edge |
| fill_set | input | SET_W | Set being filled; also selects the viewed set |
| victim_way | output | IDX_W | Way to evict from fill_set |
| mru_view | output | WAYS | Flag vector of fill_set |

## Verification
The bench builds the block with 12 ways and 2 sets. With 12 ways, the collapse happens at the realistic width, and the 4-bit way index can carry the out-of-range values 12 to 15. With 2 sets, cross-set isolation and same-cycle hits to the other set are exercised. A pseudo-random sweep drives every combination of hit, fill, set and way index, and compares each cycle with a vector model built from the requirements. A cyclic 13-address replay measures the steady-state miss count per round.

// File: rtl/mru_repl_pkg.sv
package mru_repl_pkg;

   // Bits needed to index n items (at least one).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   localparam int unsigned MAX_SETS = 64;

endpackage

// File: rtl/mru_vec_update.sv
module mru_vec_update #(
   parameter int unsigned WAYS  = 12,
   parameter int unsigned IDX_W = 4
) (
   input  logic [WAYS-1:0]  vec_i,
   input  logic             en_i,
   input  logic [IDX_W-1:0] way_i,
   output logic [WAYS-1:0]  vec_o
);
   logic [WAYS-1:0] touch;
   logic [WAYS-1:0] merged;

   always_comb begin
      for (int i = 0; i < WAYS; i++) begin
         touch[i] = en_i && (way_i == IDX_W'(i));
      end
   end

   assign merged = vec_i | touch;
   // Saturation collapses the vector onto the touched way.
   assign vec_o  = (&merged && |touch) ? touch : merged;

endmodule

// File: rtl/mru_victim_enc.sv
module mru_victim_enc #(
   parameter int unsigned WAYS  = 12,
   parameter int unsigned IDX_W = 4
) (
   input  logic [WAYS-1:0]  mru_i,
   output logic [IDX_W-1:0] victim_o
);
   // Lowest clear flag wins; scan downward so the lowest index is written last.
   always_comb begin
      victim_o = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!mru_i[i]) victim_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/mru_set_slice.sv
module mru_set_slice #(
   parameter int unsigned WAYS  = 12,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_en,
   input  logic [IDX_W-1:0] hit_way,
   input  logic             fill_en,
   output logic [WAYS-1:0]  state_q,
   output logic [IDX_W-1:0] victim
);
   logic [WAYS-1:0] after_hit;
   logic [WAYS-1:0] after_fill;

   mru_vec_update #(.WAYS(WAYS), .IDX_W(IDX_W)) u_hit_upd (
      .vec_i (state_q),
      .en_i  (hit_en),
      .way_i (hit_way),
      .vec_o (after_hit)
   );

   mru_victim_enc #(.WAYS(WAYS), .IDX_W(IDX_W)) u_enc (
      .mru_i    (after_hit),
      .victim_o (victim)
   );

   mru_vec_update #(.WAYS(WAYS), .IDX_W(IDX_W)) u_fill_upd (
      .vec_i (after_hit),
      .en_i  (fill_en),
      .way_i (victim),
      .vec_o (after_fill)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= after_fill;
   end

endmodule

// File: rtl/mru_repl_ctrl.sv
module mru_repl_ctrl
   import mru_repl_pkg::*;
#(
   parameter  int unsigned WAYS  = 12,
   parameter  int unsigned SETS  = 2,
   localparam int unsigned IDX_W = idx_width(WAYS),
   localparam int unsigned SET_W = idx_width(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_vld,
   input  logic [SET_W-1:0] hit_set,
   input  logic [IDX_W-1:0] hit_way,
   input  logic             fill_req,
   input  logic [SET_W-1:0] fill_set,
   output logic [IDX_W-1:0] victim_way,
   output logic [WAYS-1:0]  mru_view
);
   if (WAYS < 2) begin : g_bad_ways
      $error("mru_repl_ctrl: WAYS must be at least 2");
   end
   if (SETS < 1 || SETS > MAX_SETS) begin : g_bad_sets
      $error("mru_repl_ctrl: SETS out of range");
   end

   logic [WAYS-1:0]  st_q [SETS];
   logic [IDX_W-1:0] vic  [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic hit_en;
      logic fill_en;
      if (SETS == 1) begin : g_single
         assign hit_en  = hit_vld;
         assign fill_en = fill_req;
      end else begin : g_multi
         assign hit_en  = hit_vld  && (hit_set  == SET_W'(s));
         assign fill_en = fill_req && (fill_set == SET_W'(s));
      end

      mru_set_slice #(.WAYS(WAYS), .IDX_W(IDX_W)) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit_en  (hit_en),
         .hit_way (hit_way),
         .fill_en (fill_en),
         .state_q (st_q[s]),
         .victim  (vic[s])
      );
   end

   if (SETS == 1) begin : g_out_single
      assign victim_way = vic[0];
      assign mru_view   = st_q[0];
   end else begin : g_out_multi
      always_comb begin
         victim_way = '0;
         mru_view   = '0;
         for (int s = 0; s < SETS; s++) begin
            if (fill_set == SET_W'(s)) begin
               victim_way = vic[s];
               mru_view   = st_q[s];
            end
         end
      end
   end

endmodule

// File: rtl/mru_repl_chk.sv
module mru_repl_chk #(
   parameter int unsigned WAYS  = 12,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned SET_W = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit_vld,
   input logic [SET_W-1:0] hit_set,
   input logic [IDX_W-1:0] hit_way,
   input logic             fill_req,
   input logic [SET_W-1:0] fill_set,
   input logic [IDX_W-1:0] victim_way,
   input logic [WAYS-1:0]  mru_view
);
   function automatic logic [WAYS-1:0] below_mask(input logic [IDX_W-1:0] v);
      logic [WAYS-1:0] m;
      for (int i = 0; i < WAYS; i++) m[i] = (i < int'(v));
      return m;
   endfunction

   logic hit_same_set;
   assign hit_same_set = hit_vld && (hit_set == fill_set);

   // R9: victim index stays inside the way range
   assert_victim_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(victim_way) < WAYS);

   // R4: a stored vector is never fully saturated
   assert_never_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mru_view));

   // R3: with no same-set hit, the victim flag is clear and all lower flags are set
   assert_victim_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !hit_same_set) |-> !mru_view[victim_way]);

   assert_lower_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !hit_same_set) |->
         ((mru_view & below_mask(victim_way)) == below_mask(victim_way)));

   // R5: the reported victim is marked after the fill edge
   assert_fill_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |=> (fill_set != $past(fill_set)) || mru_view[$past(victim_way)]);

   // R2: a hit to the viewed set marks its way
   assert_hit_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_same_set && !fill_req && int'(hit_way) < WAYS) |=>
         (fill_set != $past(fill_set)) || mru_view[$past(hit_way)]);

   // R7: out-of-range hit alone leaves the viewed vector untouched
   assert_bad_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vld && int'(hit_way) >= WAYS && !fill_req) |=>
         (fill_set != $past(fill_set)) || $stable(mru_view));

endmodule

bind mru_repl_ctrl mru_repl_chk #(.WAYS(WAYS), .IDX_W(IDX_W), .SET_W(SET_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hit_vld    (hit_vld),
   .hit_set    (hit_set),
   .hit_way    (hit_way),
   .fill_req   (fill_req),
   .fill_set   (fill_set),
   .victim_way (victim_way),
   .mru_view   (mru_view)
);

// File: tb/sim_mru_repl_ctrl.sv
`timescale 1ns/1ps
module sim_mru_repl_ctrl;
   localparam int NW = 12;
   localparam int NS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hit_vld = 1'b0;
   logic [0:0]  hit_set = '0;
   logic [3:0]  hit_way = '0;
   logic        fill_req = 1'b0;
   logic [0:0]  fill_set = '0;
   logic [3:0]  victim_way;
   logic [11:0] mru_view;

   int n_run  = 0;
   int n_fail = 0;
   logic [11:0] mdl [NS];

   always #5 clk = ~clk;

   mru_repl_ctrl #(.WAYS(NW), .SETS(NS)) u0 (
      .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_set(hit_set),
      .hit_way(hit_way), .fill_req(fill_req), .fill_set(fill_set),
      .victim_way(victim_way), .mru_view(mru_view)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Requirement model: raise flag, collapse on saturation.
   function automatic logic [11:0] touch(input logic [11:0] v, input int w);
      logic [11:0] m;
      if (w >= NW) return v;
      m = v | (12'h1 << w);
      if (&m) m = 12'h1 << w;
      return m;
   endfunction

   function automatic int lowest_clear(input logic [11:0] v);
      for (int i = 0; i < NW; i++) if (!v[i]) return i;
      return 0;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; hit_vld = 1'b0; fill_req = 1'b0;
      repeat (2) @(negedge clk);
      for (int s = 0; s < NS; s++) begin
         fill_set = s[0:0];
         #1;
         chk("R1 view in reset", int'(mru_view), 0);
         chk("R1 victim in reset", int'(victim_way), 0);
      end
      fill_set = '0;
      rst_n = 1'b1;
      for (int s = 0; s < NS; s++) mdl[s] = '0;
   endtask

   task automatic step(input string req, input logic hv, input int hs, input int hw,
                       input logic fr, input int fs, output int vic);
      logic [11:0] mid;
      int expv;
      @(negedge clk);
      hit_vld = hv; hit_set = hs[0:0]; hit_way = hw[3:0];
      fill_req = fr; fill_set = fs[0:0];
      #1;
      vic = int'(victim_way);
      mid = (hv && hs == fs) ? touch(mdl[fs], hw) : mdl[fs];
      expv = lowest_clear(mid);
      if (fr) chk({req, " victim"}, vic, expv);
      if (hv) mdl[hs] = touch(mdl[hs], hw);
      if (fr) mdl[fs] = touch(mdl[fs], expv);
      @(posedge clk);
      #1;
      chk({req, " view"}, int'(mru_view), int'(mdl[fs]));
      hit_vld = 1'b0; fill_req = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int v;
      int lfsr;
      int tags [NW];
      int seq [22];
      int misses;
      int found;

      do_reset();
      #1;
      chk("R1 view after reset", int'(mru_view), 0);
      chk("R1 victim after reset", int'(victim_way), 0);
      chk("R9 victim width", $bits(victim_way), 4);

      step("R2 hit way5", 1, 0, 5, 0, 0, v);
      chk("R2 bit5 set", int'(mru_view), 12'h020);
      step("R2 hit way0", 1, 0, 0, 0, 0, v);
      step("R2 hit way1", 1, 0, 1, 0, 0, v);
      step("R2 hit way2", 1, 0, 2, 0, 0, v);
      @(negedge clk); fill_set = '0; #1;
      chk("R3 lowest clear", int'(victim_way), 3);

      for (int w = 0; w < NW; w++) step("R4 sweep", 1, 0, w, 0, 0, v);
      chk("R4 collapse", int'(mru_view), 12'h800);

      step("R5 fill", 0, 0, 0, 1, 0, v);
      chk("R5 victim was 0", v, 0);
      chk("R5 marked", int'(mru_view), 12'h801);

      step("R6 hit+fill", 1, 0, 1, 1, 0, v);
      chk("R6 victim after hit", v, 2);
      chk("R6 both applied", int'(mru_view), 12'h807);

      step("R7 way12", 1, 0, 12, 0, 0, v);
      step("R7 way15", 1, 0, 15, 0, 0, v);
      chk("R7 unchanged", int'(mru_view), 12'h807);

      step("R8 other set", 1, 1, 3, 0, 0, v);
      chk("R8 set0 intact", int'(mru_view), 12'h807);
      step("R8 view set1", 0, 0, 0, 0, 1, v);
      chk("R8 set1 only way3", int'(mru_view), 12'h008);
      step("R8 fill set1 with set0 hit", 1, 0, 4, 1, 1, v);
      chk("R8 set1 victim", v, 0);

      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
         step("R3/R6/R7/R8 sweep", lfsr[0], lfsr[5], (lfsr >> 1) & 15,
              lfsr[6], lfsr[7], v);
      end

      // R10 cyclic conflict pattern on one set
      do_reset();
      for (int w = 0; w < NW; w++) tags[w] = -1;
      seq[0] = 0;
      for (int k = 1; k <= 10; k++) seq[k] = k;
      seq[11] = 11;
      for (int k = 1; k <= 9; k++) seq[11 + k] = k;
      seq[21] = 12;
      for (int r = 1; r <= 8; r++) begin
         misses = 0;
         for (int a = 0; a < 22; a++) begin
            found = -1;
            for (int w = 0; w < NW; w++) if (tags[w] == seq[a]) found = w;
            if (found >= 0) step("R10 hit", 1, 0, found, 0, 0, v);
            else begin
               step("R10 miss", 0, 0, 0, 1, 0, v);
               tags[v] = seq[a];
               misses++;
            end
         end
         if (r >= 3) chk("R10 misses per round", misses, 2);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule